// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a small direct-mapped data cache. It sits between a processor request port and a simple word-wide main-memory port. Each line holds one data word, plus a tag, a valid flag and a dirty flag. A request is served from the cache when its tag matches a valid line. Otherwise the block goes to memory, and it holds only one request at a time.

A static mode input selects the write policy. In write-through mode (`wb_mode_i` = 0), every processor write is sent straight on to memory, and a write that misses does not allocate a line. In write-back mode (`wb_mode_i` = 1), a write touches only the cache and marks the line dirty. Memory receives the line only when that line is evicted, and a write that misses allocates the line.

Address layout: the index is `addr[IDX_W-1:0]` and the tag is `addr[ADDR_W-1:IDX_W]`. A request is accepted on a rising edge where `cpu_req_i` and `cpu_rdy_o` are both high. A memory transfer takes place on a rising edge where `mem_req_o` and `mem_rdy_i` are both high. Read data from memory comes back on a later cycle with `mem_rvalid_i` high.

Top module: `dm_cache`

## Requirements
- R1: While reset is low and after reset, `cpu_rdy_o` is 1, `cpu_done_o` is 0 and `mem_req_o` is 0. Reset clears every valid and dirty flag, so the first read of any address misses.
- R2: A read that hits makes no memory request. `cpu_done_o` rises on the first rising edge after acceptance and stays high for exactly one cycle, with the cached word on `cpu_rdata_o`.
- R3: A read that misses issues one memory read of the request address and returns that word. The word is installed, so the next read of the same address hits.
- R4: In write-through mode, a write hit updates the cached word and also issues one memory write of the request address and data. `cpu_done_o` follows only after memory accepts the write.
- R5: In write-through mode, a write miss issues one memory write and no memory read, and leaves the cache unchanged. A later read of that address therefore misses.
- R6: In write-back mode, a write hit makes no memory request. It updates the cached word and sets the line's dirty flag.
- R7: In write-back mode, a miss that replaces a dirty line first writes the old word to memory at the address `{old tag, index}`. Only then does it issue the memory read for the new address.
- R8: In write-back mode, replacing a clean line makes no memory write.
- R9: In write-back mode, a write miss fetches the line and merges the write data into it, leaving the line dirty. A later eviction of that line writes the merged data back.
- R10: `cpu_rdy_o` stays low from acceptance until `cpu_done_o`, and whenever `mem_req_o` is high. A memory request keeps its address, data and direction unchanged until `mem_rdy_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode_i | input | 1 | Write policy: 1 = write-back, 0 = write-through (static) |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_we_i | input | 1 | Request is a write |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdy_o | output | 1 | Block can accept a request |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read result, valid with `cpu_done_o` |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdy_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
A hit completes exactly one edge after acceptance: one lookup cycle, then a one-cycle done pulse. The bench counts falling edges from acceptance and expects the pulse on the second one. Miss and write-through latencies depend on the memory model, which waits a fixed number of cycles before accepting. For these, the bench waits for the done pulse and checks that ready never rose before it. It then compares the memory model's own logs of transfer order, address and data against values computed from the address layout and the initial memory pattern.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_WT_WRITE
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic             wr_valid_i,
  input  logic             wr_dirty_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic             valid_q [LINES];
  logic             dirty_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel;
    assign sel = wr_en_i && (rd_idx_i == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (sel) begin
        valid_q[i] <= wr_valid_i;
        dirty_q[i] <= wr_dirty_i;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[i] <= wr_tag_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] word_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en_i && (idx_i == IDX_W'(i))) begin
        word_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = word_q[idx_i];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_rdy_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rdy_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  lk_idx_o,
  input  logic              lk_valid_i,
  input  logic              lk_dirty_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic              tw_en_o,
  output logic              tw_valid_o,
  output logic              tw_dirty_o,
  output logic [TAG_W-1:0]  tw_tag_o,
  output logic              dw_en_o,
  output logic [DATA_W-1:0] dw_data_o
);
  cache_state_e      state_q, state_d;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              accept;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [TAG_W-1:0]  req_tag;
  logic              hit;
  logic              victim_dirty;

  assign lk_idx_o     = req_addr_q[IDX_W-1:0];
  assign req_tag      = req_addr_q[ADDR_W-1:IDX_W];
  assign hit          = lk_valid_i && (lk_tag_i == req_tag);
  assign victim_dirty = wb_mode_i && lk_valid_i && lk_dirty_i;

  always_comb begin
    state_d     = state_q;
    accept      = 1'b0;
    done_d      = 1'b0;
    rdata_d     = rdata_q;
    cpu_rdy_o   = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = req_addr_q;
    mem_wdata_o = req_wdata_q;
    tw_en_o     = 1'b0;
    tw_valid_o  = 1'b1;
    tw_dirty_o  = 1'b0;
    tw_tag_o    = req_tag;
    dw_en_o     = 1'b0;
    dw_data_o   = req_wdata_q;

    unique case (state_q)
      ST_IDLE: begin
        cpu_rdy_o = 1'b1;
        if (cpu_req_i) begin
          accept  = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          if (!req_we_q) begin
            done_d  = 1'b1;
            rdata_d = lk_data_i;
            state_d = ST_IDLE;
          end else begin
            dw_en_o    = 1'b1;
            tw_en_o    = 1'b1;
            tw_dirty_o = wb_mode_i;
            if (wb_mode_i) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_WT_WRITE;
            end
          end
        end else if (req_we_q && !wb_mode_i) begin
          state_d = ST_WT_WRITE;
        end else if (victim_dirty) begin
          state_d = ST_EVICT;
        end else begin
          state_d = ST_FILL_REQ;
        end
      end
      ST_EVICT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {lk_tag_i, lk_idx_o};
        mem_wdata_o = lk_data_i;
        if (mem_rdy_i) state_d = ST_FILL_REQ;
      end
      ST_FILL_REQ: begin
        mem_req_o = 1'b1;
        if (mem_rdy_i) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_rvalid_i) begin
          tw_en_o    = 1'b1;
          tw_dirty_o = req_we_q;
          dw_en_o    = 1'b1;
          dw_data_o  = req_we_q ? req_wdata_q : mem_rdata_i;
          rdata_d    = mem_rdata_i;
          done_d     = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_WT_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_rdy_i) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_we_q    <= cpu_we_i;
      req_addr_q  <= cpu_addr_i;
      req_wdata_q <= cpu_wdata_i;
    end
    if (done_d) begin
      rdata_q <= rdata_d;
    end
  end

  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_rdy_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rdy_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic              tw_en, tw_valid, tw_dirty;
  logic [TAG_W-1:0]  tw_tag;
  logic              dw_en;
  logic [DATA_W-1:0] dw_data;

  cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wb_mode_i(wb_mode_i),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdy_o(cpu_rdy_o), .cpu_done_o(cpu_done_o),
    .cpu_rdata_o(cpu_rdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdy_i(mem_rdy_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .lk_idx_o(lk_idx), .lk_valid_i(lk_valid), .lk_dirty_i(lk_dirty),
    .lk_tag_i(lk_tag), .lk_data_i(lk_data),
    .tw_en_o(tw_en), .tw_valid_o(tw_valid), .tw_dirty_o(tw_dirty),
    .tw_tag_o(tw_tag), .dw_en_o(dw_en), .dw_data_o(dw_data)
  );

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_idx_i(lk_idx),
    .rd_valid_o(lk_valid), .rd_dirty_o(lk_dirty), .rd_tag_o(lk_tag),
    .wr_en_i(tw_en), .wr_valid_i(tw_valid), .wr_dirty_i(tw_dirty),
    .wr_tag_i(tw_tag)
  );

  cache_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .idx_i(lk_idx), .rd_data_o(lk_data),
    .wr_en_i(dw_en), .wr_data_i(dw_data)
  );
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_i,
  input logic              cpu_rdy_o,
  input logic              cpu_done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_rdy_i
);
  // R10: never ready for a new request while memory traffic is pending
  a_r10_busy_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !cpu_rdy_o);

  // R10: an unaccepted memory request holds its contents
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R10: acceptance closes the request port for at least the lookup cycle
  a_r10_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_i && cpu_rdy_o |=> !cpu_rdy_o && !cpu_done_o);

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o |=> !cpu_done_o);

  // R3: completion never overlaps an open memory request
  a_r3_done_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o |-> !mem_req_o);
endmodule

bind dm_cache cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req_i), .cpu_rdy_o(cpu_rdy_o),
  .cpu_done_o(cpu_done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdy_i(mem_rdy_i)
);

// File: tb/tb_dm_cache.sv
module tb_dm_cache;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wb_mode = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_rdy, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rdy, mem_rvalid;
  logic [DW-1:0] mem_rdata;

  always #4 clk = ~clk;

  dm_cache dut (
    .clk(clk), .rst_n(rst_n), .wb_mode_i(wb_mode),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdy_o(cpu_rdy), .cpu_done_o(cpu_done),
    .cpu_rdata_o(cpu_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // memory model: accepts after a fixed wait, logs every transfer
  logic [DW-1:0] mem [256];
  int            wait_cnt;
  int            n_rd = 0, n_wr = 0, n_log = 0;
  logic          log_we   [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | DW'(a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rdy    <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      wait_cnt   <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= init_val(AW'(i));
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req && mem_rdy) begin
        mem_rdy  <= 1'b0;
        wait_cnt <= 0;
        log_we[n_log % 64]   <= mem_we;
        log_addr[n_log % 64] <= mem_addr;
        log_data[n_log % 64] <= mem_wdata;
        n_log <= n_log + 1;
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr[7:0]];
          n_rd <= n_rd + 1;
        end
      end else if (mem_req) begin
        if (wait_cnt == 2) mem_rdy <= 1'b1;
        else wait_cnt <= wait_cnt + 1;
      end
    end
  end

  int n_checks = 0, n_errors = 0;
  int last_lat;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    bit busy_ok = 1'b1;
    int lat;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!cpu_rdy) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_done && lat < 1000) begin
      if (cpu_rdy) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
    last_lat = lat;
    check("R10 ready low until done", DW'(busy_ok), 32'd1);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; wb_mode = mode;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", DW'(cpu_rdy), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", DW'(cpu_rdy), 32'd1);
    check("R1 no done after reset", DW'(cpu_done), 32'd0);
    check("R1 no mem req after reset", DW'(mem_req), 32'd0);
  endtask

  task automatic t_read_miss_then_hit;
    logic [DW-1:0] d; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    access(1'b0, 12'h010, '0, d);
    check("R1 first read misses", DW'(n_rd - r0), 32'd1);
    check("R3 miss data", d, init_val(12'h010));
    check("R3 miss address", DW'(log_addr[(n_log-1) % 64]), 32'h010);
    r0 = n_rd;
    access(1'b0, 12'h010, '0, d);
    check("R2 hit no mem read", DW'(n_rd - r0), 32'd0);
    check("R2 hit latency", DW'(last_lat), 32'd2);
    check("R2 hit data", d, init_val(12'h010));
    check("R2 no writes on reads", DW'(n_wr - w0), 32'd0);
  endtask

  task automatic t_wt_write_hit;
    logic [DW-1:0] d; int r0, w0;
    w0 = n_wr;
    access(1'b1, 12'h010, 32'h1111_AAAA, d);
    check("R4 one mem write", DW'(n_wr - w0), 32'd1);
    check("R4 memory updated", mem[8'h10], 32'h1111_AAAA);
    r0 = n_rd;
    access(1'b0, 12'h010, '0, d);
    check("R4 cache updated", d, 32'h1111_AAAA);
    check("R4 read after write hits", DW'(n_rd - r0), 32'd0);
  endtask

  task automatic t_wt_write_miss;
    logic [DW-1:0] d; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    access(1'b1, 12'h021, 32'h2222_BBBB, d);
    check("R5 one mem write", DW'(n_wr - w0), 32'd1);
    check("R5 no mem read", DW'(n_rd - r0), 32'd0);
    check("R5 memory updated", mem[8'h21], 32'h2222_BBBB);
    r0 = n_rd;
    access(1'b0, 12'h021, '0, d);
    check("R5 no allocate: read misses", DW'(n_rd - r0), 32'd1);
    check("R5 read data", d, 32'h2222_BBBB);
  endtask

  task automatic t_wb_write_hit;
    logic [DW-1:0] d; int r0, w0;
    access(1'b0, 12'h012, '0, d);
    r0 = n_rd; w0 = n_wr;
    access(1'b1, 12'h012, 32'h3333_CCCC, d);
    check("R6 no mem write", DW'(n_wr - w0), 32'd0);
    check("R6 no mem read", DW'(n_rd - r0), 32'd0);
    check("R6 memory untouched", mem[8'h12], init_val(12'h012));
    access(1'b0, 12'h012, '0, d);
    check("R6 cached data", d, 32'h3333_CCCC);
  endtask

  task automatic t_wb_dirty_evict;
    logic [DW-1:0] d; int l0;
    l0 = n_log;
    access(1'b0, 12'h01A, '0, d);
    check("R7 two transfers", DW'(n_log - l0), 32'd2);
    check("R7 write first", DW'(log_we[l0 % 64]), 32'd1);
    check("R7 victim address", DW'(log_addr[l0 % 64]), 32'h012);
    check("R7 victim data", log_data[l0 % 64], 32'h3333_CCCC);
    check("R7 then read", DW'(log_we[(l0+1) % 64]), 32'd0);
    check("R7 fill address", DW'(log_addr[(l0+1) % 64]), 32'h01A);
    check("R7 new data", d, init_val(12'h01A));
  endtask

  task automatic t_wb_clean_evict;
    logic [DW-1:0] d; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    access(1'b0, 12'h022, '0, d);
    check("R8 no write for clean victim", DW'(n_wr - w0), 32'd0);
    check("R8 one read", DW'(n_rd - r0), 32'd1);
    check("R8 data", d, init_val(12'h022));
  endtask

  task automatic t_wb_write_miss;
    logic [DW-1:0] d; int r0, w0, l0;
    r0 = n_rd; w0 = n_wr;
    access(1'b1, 12'h033, 32'h4444_DDDD, d);
    check("R9 allocate fetch", DW'(n_rd - r0), 32'd1);
    check("R9 no mem write", DW'(n_wr - w0), 32'd0);
    r0 = n_rd;
    access(1'b0, 12'h033, '0, d);
    check("R9 merged data hits", d, 32'h4444_DDDD);
    check("R9 hit no read", DW'(n_rd - r0), 32'd0);
    l0 = n_log;
    access(1'b0, 12'h00B, '0, d);
    check("R9 dirty writeback first", DW'(log_we[l0 % 64]), 32'd1);
    check("R9 writeback address", DW'(log_addr[l0 % 64]), 32'h033);
    check("R9 writeback data", log_data[l0 % 64], 32'h4444_DDDD);
    check("R9 new line data", d, init_val(12'h00B));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_read_miss_then_hit();
    t_wt_write_hit();
    t_wt_write_miss();
    do_reset(1'b1);
    t_wb_write_hit();
    t_wb_dirty_evict();
    t_wb_clean_evict();
    t_wb_write_miss();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule